// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up on behalf of a memory controller. It starts on its own once synchronous reset is released, and again whenever a start pulse arrives while it is idle. It first turns periodic refresh off and waits a settling interval, about 200 µs at the default clock. It then walks a fixed list of device commands and presents each one on a 2-bit command output, together with a one-cycle valid strobe. Two issues are always at least a fixed number of idle cycles apart. The whole pass, settling interval included, runs twice. After the second pass the block turns refresh back on and pulses done.

The value written into the device's mode register is computed once, at launch, from three configuration inputs. The first is a 2-bit CAS-latency field, whose meaning depends on a 50/100 MHz speed select. The second is the data-bus width. The third is an optional override byte; when it is nonzero, it is used as it stands. The mode value appears on its own output only in the cycle that carries the mode-register-set command.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, cmd_valid, busy, done and refresh_enable are all 0, cmd is 0 and mode_data is 0. On the first clock edge with rst_n high, a sequence launches without any start pulse.
- R2: A start pulse sampled while the block is idle launches a sequence. busy is 1 from the cycle after the launch edge until the cycle in which done is 1, and busy is 0 in that cycle.
- R3: Each pass begins with a settling wait. The pass's first cmd_valid appears SETTLE_CYCLES cycles after the edge that starts the pass.
- R4: Each pass issues 2*(NUM_REFRESH+2) commands in this order: precharge-all, then NUM_REFRESH auto-refreshes, then mode-register set, with a NOP after each of these. The encodings on cmd are 0 NOP, 1 mode-register set, 2 auto-refresh and 3 precharge-all.
- R5: Exactly CMD_GAP cycles with cmd_valid low lie between two successive issues within a pass. cmd_valid is never high for two consecutive cycles.
- R6: refresh_enable is 0 whenever busy is 1. It becomes 1 in the done cycle and stays 1 until the next launch.
- R7: With a zero override and a 32-bit bus, the mode value is 0x40 for latency 2 and 0x60 for latency 3. At 100 MHz (speed select 1), field value 0 means latency 2. At 50 MHz (speed select 0), field value 1 means latency 2. Every other field value means latency 3.
- R8: With a zero override and a 16-bit bus (width select 0), the mode value is the 32-bit value shifted right by one bit, giving 0x20 or 0x30.
- R9: A nonzero override byte is used as the mode value unchanged, whatever the latency field, speed select or width select.
- R10: mode_data carries the mode value only in a cycle where cmd_valid is 1 and cmd is 1. In every other cycle it is 0.
- R11: The sequence runs PASSES times, and the second pass starts with its own settling wait. done is a one-cycle pulse, CMD_GAP+1 cycles after the last issue of the final pass.
- R12: A start pulse that arrives while busy is 1 is ignored. It does not change the command stream, its timing or the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, acted on only when idle |
| cfg_cas | input | 2 | CAS-latency field |
| cfg_fast | input | 1 | Speed select: 1 = 100 MHz, 0 = 50 MHz |
| cfg_wide | input | 1 | Bus width select: 1 = 32-bit, 0 = 16-bit |
| cfg_mode_ovr | input | 8 | Mode value override, 0 = compute it |
| cmd | output | 2 | Command code, meaningful with cmd_valid |
| cmd_valid | output | 1 | One-cycle strobe per issued command |
| mode_data | output | 8 | Mode value, nonzero only alongside mode-register set |
| refresh_enable | output | 1 | Periodic refresh allowed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Cycles are counted from the launch edge, with cycle 0 being the first cycle after it. Entry j of pass p is due at cycle p*(SETTLE_CYCLES + LIST_LEN*(CMD_GAP+1)) + SETTLE_CYCLES + j*(CMD_GAP+1). done and the rise of refresh_enable are due at cycle PASSES times that pass length. The bench turns these formulas into an expected value for every output on every cycle. It samples at the falling edge, so each registered result is read half a cycle after the edge that produced it. It applies start pulses mid-run, and the same schedule must still hold afterwards.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM initialization sequencer.
// Assumes: command codes match the memory controller's 2-bit command field.
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_MRS = 2'd1,
        CMD_REF = 2'd2,
        CMD_PRE = 2'd3
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_e;

    localparam logic [7:0] MODE_BASE = 8'h40;
    localparam logic [7:0] MODE_LAT3 = 8'h20;

endpackage

// File: rtl/sdram_mode_calc.sv
// Mode-register value calculation.
// Computes the value from the latency field, speed select and bus width.
// A nonzero override bypasses the calculation entirely.
// Assumes: inputs are static while a launch samples the result.
module sdram_mode_calc
    import sdram_init_pkg::*;
(
    input  logic [1:0] cas_field,
    input  logic       speed_fast,
    input  logic       bus_wide,
    input  logic [7:0] override_val,
    output logic [7:0] mode_val
);

    logic       lat3;
    logic [7:0] wide_val;

    // Decode the latency: the field code that means latency 2 depends on the speed.
    always_comb begin
        if (speed_fast) lat3 = (cas_field != 2'd0);
        else            lat3 = (cas_field != 2'd1);
    end

    // Build the 32-bit value, halve it for a 16-bit bus, then apply the override.
    always_comb begin
        wide_val = MODE_BASE | (lat3 ? MODE_LAT3 : 8'h00);
        if (override_val != 8'h00) mode_val = override_val;
        else if (bus_wide)         mode_val = wide_val;
        else                       mode_val = wide_val >> 1;
    end

endmodule

// File: rtl/sdram_cmd_list.sv
// Computed initialization command list.
// Even slots hold precharge, NUM_REFRESH refreshes and mode set; odd slots hold NOP.
// Assumes: idx stays below LIST_LEN.
module sdram_cmd_list
    import sdram_init_pkg::*;
#(
    parameter int NUM_REFRESH = 8,
    parameter int LIST_LEN    = 2 * (NUM_REFRESH + 2),
    parameter int IDX_W       = $clog2(LIST_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    output sdram_cmd_e       entry,
    output logic             is_last
);

    localparam logic [IDX_W-1:0] MRS_SLOT  = IDX_W'(LIST_LEN - 2);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(LIST_LEN - 1);

    // Map a slot index onto its command.
    always_comb begin
        if (idx[0])                entry = CMD_NOP;
        else if (idx == '0)        entry = CMD_PRE;
        else if (idx == MRS_SLOT)  entry = CMD_MRS;
        else                       entry = CMD_REF;
        is_last = (idx == LAST_SLOT);
    end

endmodule

// File: rtl/sdram_wait_counter.sv
// Loadable down-counter for the settling and spacing waits.
// It holds at zero once reached. A load takes priority over counting.
module sdram_wait_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load, or count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer (top).
// Launches after reset release or on an idle start pulse. Each pass waits
// SETTLE_CYCLES, then issues the command list with CMD_GAP idle cycles between
// issues. It runs PASSES passes, then re-enables refresh and pulses done.
// Assumes: SETTLE_CYCLES >= 1, CMD_GAP >= 1, PASSES >= 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int SETTLE_CYCLES = 10000,
    parameter int CMD_GAP       = 5,
    parameter int PASSES        = 2,
    parameter int NUM_REFRESH   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] cfg_cas,
    input  logic       cfg_fast,
    input  logic       cfg_wide,
    input  logic [7:0] cfg_mode_ovr,
    output logic [1:0] cmd,
    output logic       cmd_valid,
    output logic [7:0] mode_data,
    output logic       refresh_enable,
    output logic       busy,
    output logic       done
);

    localparam int LIST_LEN = 2 * (NUM_REFRESH + 2);
    localparam int IDX_W    = $clog2(LIST_LEN);
    localparam int PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int CNT_MAX  = (SETTLE_CYCLES - 1 > CMD_GAP) ? SETTLE_CYCLES - 1 : CMD_GAP;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int SINCE_W  = $clog2(CMD_GAP + 1);
    localparam logic [CNT_W-1:0]  SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0]  GAP_LOAD    = CNT_W'(CMD_GAP);
    localparam logic [PASS_W-1:0] LAST_PASS   = PASS_W'(PASSES - 1);

    seq_state_e        state_q;
    logic              pending_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wrap_q;
    logic [PASS_W-1:0] pass_q;
    logic [7:0]        mode_q;
    sdram_cmd_e        cmd_q;
    logic              valid_q;
    logic [7:0]        mdout_q;
    logic              ref_en_q;
    logic              done_q;

    logic [7:0]        mode_calc_val;
    sdram_cmd_e        list_entry;
    logic              list_last;
    logic              wait_zero;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              kick;
    logic              do_issue;
    logic              do_next_pass;
    logic              do_finish;

    sdram_mode_calc u_mode (
        .cas_field    (cfg_cas),
        .speed_fast   (cfg_fast),
        .bus_wide     (cfg_wide),
        .override_val (cfg_mode_ovr),
        .mode_val     (mode_calc_val)
    );

    sdram_cmd_list #(
        .NUM_REFRESH (NUM_REFRESH),
        .LIST_LEN    (LIST_LEN),
        .IDX_W       (IDX_W)
    ) u_list (
        .idx     (idx_q),
        .entry   (list_entry),
        .is_last (list_last)
    );

    sdram_wait_counter #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .is_zero  (wait_zero)
    );

    // Decide this cycle's action: issue, start another pass, or finish.
    always_comb begin
        kick         = pending_q | start;
        do_issue     = 1'b0;
        do_next_pass = 1'b0;
        do_finish    = 1'b0;
        if (wait_zero) begin
            if (state_q == ST_SETTLE) begin
                do_issue = 1'b1;
            end else if (state_q == ST_GAP) begin
                if (!wrap_q)                  do_issue     = 1'b1;
                else if (pass_q == LAST_PASS) do_finish    = 1'b1;
                else                          do_next_pass = 1'b1;
            end
        end
        cnt_load = ((state_q == ST_IDLE) && kick) | do_issue | do_next_pass;
        cnt_val  = do_issue ? GAP_LOAD : SETTLE_LOAD;
    end

    // Sequencer state, list position, pass count and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b1;
            idx_q     <= '0;
            wrap_q    <= 1'b0;
            pass_q    <= '0;
            mode_q    <= 8'h00;
            cmd_q     <= CMD_NOP;
            valid_q   <= 1'b0;
            mdout_q   <= 8'h00;
            ref_en_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            cmd_q   <= CMD_NOP;
            mdout_q <= 8'h00;
            done_q  <= 1'b0;
            if (state_q == ST_IDLE && kick) begin
                pending_q <= 1'b0;
                state_q   <= ST_SETTLE;
                idx_q     <= '0;
                wrap_q    <= 1'b0;
                pass_q    <= '0;
                ref_en_q  <= 1'b0;
                mode_q    <= mode_calc_val;
            end
            if (do_issue) begin
                state_q <= ST_GAP;
                valid_q <= 1'b1;
                cmd_q   <= list_entry;
                mdout_q <= (list_entry == CMD_MRS) ? mode_q : 8'h00;
                wrap_q  <= list_last;
                idx_q   <= list_last ? '0 : idx_q + 1'b1;
            end
            if (do_next_pass) begin
                state_q <= ST_SETTLE;
                wrap_q  <= 1'b0;
                pass_q  <= pass_q + 1'b1;
            end
            if (do_finish) begin
                state_q  <= ST_IDLE;
                ref_en_q <= 1'b1;
                done_q   <= 1'b1;
            end
        end
    end

    assign cmd            = cmd_q;
    assign cmd_valid      = valid_q;
    assign mode_data      = mdout_q;
    assign refresh_enable = ref_en_q;
    assign busy           = (state_q != ST_IDLE);
    assign done           = done_q;

    // Count the idle cycles since the last issue, saturating at CMD_GAP.
    logic [SINCE_W-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_q <= SINCE_W'(CMD_GAP);
        else if (valid_q)                    since_q <= '0;
        else if (since_q != SINCE_W'(CMD_GAP)) since_q <= since_q + 1'b1;
    end

    assert_issue_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (since_q == SINCE_W'(CMD_GAP)));

    assert_valid_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    assert_refresh_held_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !refresh_enable);

    assert_done_closes_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (refresh_enable && !busy && $past(busy)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_mode_only_with_mrs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_data != 8'h00) |-> (cmd_valid && cmd == CMD_MRS));

    assert_mode_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_ovr == 8'h00) |-> (mode_calc_val inside {8'h20, 8'h30, 8'h40, 8'h60}));

endmodule

// File: tb/sim_sdram_init_seq.sv
// Bench: a behavioural schedule predicts every output on every cycle.
module sim_sdram_init_seq;

    localparam int S = 20;
    localparam int G = 5;
    localparam int P = 2;
    localparam int NR = 8;
    localparam int LLEN = 2 * (NR + 2);
    localparam int PLEN = S + LLEN * (G + 1);
    localparam int TOTAL = P * PLEN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cfg_cas = 2'd0;
    logic       cfg_fast = 1'b1;
    logic       cfg_wide = 1'b1;
    logic [7:0] cfg_mode_ovr = 8'h00;
    logic [1:0] cmd;
    logic       cmd_valid;
    logic [7:0] mode_data;
    logic       refresh_enable;
    logic       busy;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .SETTLE_CYCLES (S),
        .CMD_GAP       (G),
        .PASSES        (P),
        .NUM_REFRESH   (NR)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cfg_cas        (cfg_cas),
        .cfg_fast       (cfg_fast),
        .cfg_wide       (cfg_wide),
        .cfg_mode_ovr   (cfg_mode_ovr),
        .cmd            (cmd),
        .cmd_valid      (cmd_valid),
        .mode_data      (mode_data),
        .refresh_enable (refresh_enable),
        .busy           (busy),
        .done           (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Expected mode value from the configuration (R7, R8, R9).
    function automatic int exp_mode(input int fast, input int cas, input int wide, input int ovr);
        int v;
        bit lat3;
        if (ovr != 0) return ovr;
        lat3 = fast ? (cas != 0) : (cas != 1);
        v = lat3 ? 'h60 : 'h40;
        if (!wide) v = v / 2;
        return v;
    endfunction

    // Expected command at list slot j (R4).
    function automatic int exp_cmd(input int j);
        if (j % 2 == 1) return 0;
        if (j == 0) return 3;
        if (j == LLEN - 2) return 1;
        return 2;
    endfunction

    // Follow one launched run from cycle 0; optionally pulse start at poke_c (R12).
    task automatic follow_run(input int md, input int poke_c);
        for (int c = 0; c <= TOTAL + 3; c++) begin
            int off, j, ecmd, emd;
            bit ev, eb, ed, er;
            eb = (c < TOTAL);
            ed = (c == TOTAL);
            er = (c >= TOTAL);
            ev = 1'b0;
            ecmd = 0;
            emd = 0;
            if (eb) begin
                off = c % PLEN;
                if (off >= S && ((off - S) % (G + 1)) == 0) begin
                    ev = 1'b1;
                    j = (off - S) / (G + 1);
                    ecmd = exp_cmd(j);
                    emd = (ecmd == 1) ? md : 0;
                end
            end
            chk(busy == eb, "R2 busy", busy, eb);
            chk(cmd_valid == ev, "R3/R5 cmd_valid", cmd_valid, ev);
            if (ev) chk(cmd == ecmd[1:0], "R4 cmd", cmd, ecmd);
            chk(mode_data == emd[7:0], "R10 mode_data", mode_data, emd);
            chk(refresh_enable == er, "R6 refresh_enable", refresh_enable, er);
            chk(done == ed, "R11 done", done, ed);
            start = (c == poke_c);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic set_cfg(input int fast, input int cas, input int wide, input int ovr);
        cfg_fast = fast[0];
        cfg_cas = cas[1:0];
        cfg_wide = wide[0];
        cfg_mode_ovr = ovr[7:0];
    endtask

    task automatic launch_by_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state, then automatic launch on release.
        set_cfg(1, 0, 1, 0);
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(refresh_enable == 1'b0, "R1 refresh_enable", refresh_enable, 0);
        chk(cmd == 2'd0, "R1 cmd", cmd, 0);
        chk(mode_data == 8'h00, "R1 mode_data", mode_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        follow_run(exp_mode(1, 0, 1, 0), -1);         // R1, R7 (0x40)

        // R2, R12: start launches; a start mid-run is ignored.
        set_cfg(1, 1, 1, 0);
        launch_by_start();
        follow_run(exp_mode(1, 1, 1, 0), 57);          // R7 (0x60), R12

        // R8: 50 MHz, latency 2, 16-bit bus.
        set_cfg(0, 1, 0, 0);
        launch_by_start();
        follow_run(exp_mode(0, 1, 0, 0), PLEN + 3);    // R8 (0x20), R12 in second pass

        // R8: 50 MHz, field 0 means latency 3, 16-bit bus.
        set_cfg(0, 0, 0, 0);
        launch_by_start();
        follow_run(exp_mode(0, 0, 0, 0), -1);          // R8 (0x30)

        // R7: 50 MHz, field 3, 32-bit bus.
        set_cfg(0, 3, 1, 0);
        launch_by_start();
        follow_run(exp_mode(0, 3, 1, 0), -1);          // R7 (0x60)

        // R9: override used unchanged on a 16-bit bus.
        set_cfg(1, 2, 0, 'h5A);
        launch_by_start();
        follow_run(exp_mode(1, 2, 0, 'h5A), -1);       // R9 (0x5A)

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule